// File: doc/BRIEF.md
# Scanline Phase Event Sequencer

This block paces the work of a video line. A horizontal counter advances once for each master-clock enable and returns to zero at a line length that is supplied as an input. A four-state machine follows the counter through the line. Each state change fires a one-cycle event at a fixed horizontal position. At those events, register values that software writes at any time are copied into shadow registers. The shadows stay constant while the rest of the line is drawn, so a write in mid-line does not take effect in the middle of the line.

The states are `PH_SYNC` (from position 0), `PH_SHADOW` (from `POS_AFFINE`, default 10), `PH_DRAW` (from `POS_DRAW`, default 512) and `PH_TAIL` (from `POS_CFG`, default 1152 up to the end of the line). The transitions are as follows:

- `T_AFFINE` (`PH_SYNC`→`PH_SHADOW`) copies the eight affine terms. On the first blanking line it also reloads the sprite-memory address.
- `T_DRAW` (`PH_SHADOW`→`PH_DRAW`) raises the render strobe on visible lines.
- `T_CFG` (`PH_DRAW`→`PH_TAIL`) copies the sprite configuration and flags a change of sprite size.
- `T_WRAP` (any state→`PH_SYNC`) fires when the counter wraps. It issues the line-start pulse, and on line 0 it also issues the flag-clear pulse.

The line number comes from outside. The surrounding logic must present the number of the line that is about to begin before the wrap edge.

Top module: `scanline_event_seq`

## Requirements
- R1: The counter `hcnt` advances by one on each cycle with `tick_en` high. On a tick where it is at or above `line_len-1`, it becomes 0 and `line_start` is high for exactly the following cycle.
- R2: On the tick where the counter reaches `POS_AFFINE`, `aff_shadow` takes the `aff_live` value present on that tick. Lane i is bits [16i+15:16i]: lanes 0–1 are the scroll offsets, lanes 2–5 the matrix terms and lanes 6–7 the centre coordinates. At all other times the shadow holds its value.
- R3: On that same tick, if `vpos` equals 225 (240 when `overscan` is 1) and `disp_off` is 0, `spr_addr` becomes `{spr_base,1'b0}`. In every other case it holds.
- R4: When `spr_addr` is reloaded, `first_idx` becomes 0 if `prio_rot` is 0, and becomes bits [8:2] of the new address otherwise.
- R5: On the tick where the counter reaches `POS_DRAW`, `render_stb` is high for one cycle only when 1 ≤ `vpos` < 225 (< 240 with `overscan`).
- R6: On the tick where the counter reaches `POS_CFG`, the size, name and tile-base shadows take their live values. `spr_inval` is high for that one cycle only if the live size differed from the previous size shadow.
- R7: `flag_clr` is high together with `line_start` when `vpos` is 0 on the wrap tick, and is low at all other times.
- R8: After reset all shadows, `spr_addr`, `first_idx` and all pulse outputs are 0, and the counter is at 0 in `PH_SYNC`.
- R9: A cycle with `tick_en` low raises no pulse and changes no shadow or counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Master-clock enable; one dot clock per high cycle |
| line_len | input | 11 | Line length in ticks |
| vpos | input | 9 | Number of the current (or starting) line |
| overscan | input | 1 | Selects the taller picture (240 visible lines) |
| disp_off | input | 1 | Display-disable flag; blocks the address reload |
| prio_rot | input | 1 | Enables rotation of the first-sprite index |
| spr_base | input | 9 | Sprite-memory base address |
| aff_live | input | 128 | Eight live 16-bit affine terms |
| spr_size | input | 3 | Live sprite size selection |
| spr_name | input | 2 | Live sprite name select |
| spr_tile | input | 3 | Live sprite tile-data base |
| aff_shadow | output | 128 | Affine shadow copies |
| spr_size_sh | output | 3 | Sprite size shadow |
| spr_name_sh | output | 2 | Name select shadow |
| spr_tile_sh | output | 3 | Tile-data base shadow |
| spr_addr | output | 10 | Reloaded sprite-memory address |
| first_idx | output | 7 | First-sprite index |
| line_start | output | 1 | Line-start pulse |
| flag_clr | output | 1 | Clear pulse for the over-time and over-range flags (line 0) |
| render_stb | output | 1 | Render strobe on visible lines |
| spr_inval | output | 1 | Sprite-size change pulse |

## Verification
Each result has one register stage between the tick and the output. A pulse or shadow update caused by the tick on edge n is visible in the cycle after edge n and nowhere else. For every cycle, the bench predicts the next counter value from `line_len` and `tick_en`, and derives the expected pulses and shadow values from the inputs it drove before that edge. It then compares all outputs on the following falling edge. The sweeps step through every line number from 0 to 245, with normal and tall pictures, constant and random enables, and the display enabled or forced off. This puts the boundary lines 0, 1, 224/225 and 239/240 on exact cycles.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_SHADOW = 2'd1,
        PH_DRAW   = 2'd2,
        PH_TAIL   = 2'd3
    } phase_t;

    typedef struct packed {
        logic ls;
        logic aff;
        logic draw;
        logic cfg;
    } fire_t;

endpackage

// File: rtl/phase_fsm.sv
module phase_fsm
    import scan_seq_pkg::*;
#(
    parameter int HW         = 11,
    parameter int POS_AFFINE = 10,
    parameter int POS_DRAW   = 512,
    parameter int POS_CFG    = 1152
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic [HW-1:0] line_len,
    output logic [HW-1:0] hcnt,
    output fire_t         fire
);
    localparam logic [HW-1:0] H_AFF  = HW'(POS_AFFINE);
    localparam logic [HW-1:0] H_DRAW = HW'(POS_DRAW);
    localparam logic [HW-1:0] H_CFG  = HW'(POS_CFG);

    phase_t        state, nxt;
    logic [HW-1:0] h_nxt;
    logic          wrap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PH_SYNC;
            hcnt  <= '0;
        end else begin
            state <= nxt;
            hcnt  <= h_nxt;
        end
    end

    // next state
    always_comb begin
        wrap  = (hcnt >= line_len - 1'b1);
        h_nxt = hcnt;
        if (tick_en) h_nxt = wrap ? '0 : hcnt + 1'b1;
        nxt = state;
        if (tick_en) begin
            if (wrap) begin
                nxt = PH_SYNC;                              // T_WRAP
            end else begin
                unique case (state)
                    PH_SYNC:   if (h_nxt == H_AFF)  nxt = PH_SHADOW; // T_AFFINE
                    PH_SHADOW: if (h_nxt == H_DRAW) nxt = PH_DRAW;   // T_DRAW
                    PH_DRAW:   if (h_nxt == H_CFG)  nxt = PH_TAIL;   // T_CFG
                    PH_TAIL:   nxt = PH_TAIL;
                endcase
            end
        end
    end

    // outputs: one event per transition
    always_comb begin
        fire      = '0;
        fire.ls   = tick_en && wrap;
        fire.aff  = tick_en && !wrap && (state == PH_SYNC)   && (nxt == PH_SHADOW);
        fire.draw = tick_en && !wrap && (state == PH_SHADOW) && (nxt == PH_DRAW);
        fire.cfg  = tick_en && !wrap && (state == PH_DRAW)   && (nxt == PH_TAIL);
    end

endmodule

// File: rtl/line_qual.sv
module line_qual #(
    parameter int VW         = 9,
    parameter int VIS_END    = 225,
    parameter int VIS_END_OS = 240
) (
    input  logic [VW-1:0] vpos,
    input  logic          overscan,
    output logic          is_visible,
    output logic          is_vblank_start,
    output logic          is_first
);
    localparam logic [VW-1:0] LIM_N = VW'(VIS_END);
    localparam logic [VW-1:0] LIM_O = VW'(VIS_END_OS);

    logic [VW-1:0] lim;

    always_comb begin
        lim             = overscan ? LIM_O : LIM_N;
        is_visible      = (vpos != '0) && (vpos < lim);
        is_vblank_start = (vpos == lim);
        is_first        = (vpos == '0);
    end

endmodule

// File: rtl/affine_shadow.sv
module affine_shadow #(
    parameter int AW = 16,
    parameter int N  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          latch,
    input  logic [AW*N-1:0] live,
    output logic [AW*N-1:0] shadow
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     shadow[i*AW +: AW] <= '0;
            else if (latch) shadow[i*AW +: AW] <= live[i*AW +: AW];
        end
    end

endmodule

// File: rtl/spr_addr_reload.sv
module spr_addr_reload #(
    parameter int SB_W = 9,
    parameter int FI_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reload,
    input  logic            prio_rot,
    input  logic [SB_W-1:0] base,
    output logic [SB_W:0]   addr,
    output logic [FI_W-1:0] first_idx
);
    localparam int SA_W = SB_W + 1;

    logic [SA_W-1:0] new_addr;

    always_comb new_addr = {base, 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr      <= '0;
            first_idx <= '0;
        end else if (reload) begin
            addr      <= new_addr;
            first_idx <= prio_rot ? new_addr[FI_W+1:2] : '0;
        end
    end

endmodule

// File: rtl/spr_cfg_shadow.sv
module spr_cfg_shadow #(
    parameter int SZ_W = 3,
    parameter int NM_W = 2,
    parameter int TD_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            latch,
    input  logic [SZ_W-1:0] size_live,
    input  logic [NM_W-1:0] name_live,
    input  logic [TD_W-1:0] tile_live,
    output logic [SZ_W-1:0] size_sh,
    output logic [NM_W-1:0] name_sh,
    output logic [TD_W-1:0] tile_sh,
    output logic            inval
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_sh <= '0;
            name_sh <= '0;
            tile_sh <= '0;
            inval   <= 1'b0;
        end else begin
            inval <= latch && (size_live != size_sh);
            if (latch) begin
                size_sh <= size_live;
                name_sh <= name_live;
                tile_sh <= tile_live;
            end
        end
    end

endmodule

// File: rtl/scanline_event_seq.sv
module scanline_event_seq
    import scan_seq_pkg::*;
#(
    parameter int HW         = 11,
    parameter int VW         = 9,
    parameter int POS_AFFINE = 10,
    parameter int POS_DRAW   = 512,
    parameter int POS_CFG    = 1152,
    parameter int VIS_END    = 225,
    parameter int VIS_END_OS = 240,
    parameter int AW         = 16,
    parameter int N_AFF      = 8,
    parameter int SB_W       = 9,
    parameter int FI_W       = 7,
    parameter int SZ_W       = 3,
    parameter int NM_W       = 2,
    parameter int TD_W       = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic [HW-1:0]       line_len,
    input  logic [VW-1:0]       vpos,
    input  logic                overscan,
    input  logic                disp_off,
    input  logic                prio_rot,
    input  logic [SB_W-1:0]     spr_base,
    input  logic [AW*N_AFF-1:0] aff_live,
    input  logic [SZ_W-1:0]     spr_size,
    input  logic [NM_W-1:0]     spr_name,
    input  logic [TD_W-1:0]     spr_tile,
    output logic [AW*N_AFF-1:0] aff_shadow,
    output logic [SZ_W-1:0]     spr_size_sh,
    output logic [NM_W-1:0]     spr_name_sh,
    output logic [TD_W-1:0]     spr_tile_sh,
    output logic [SB_W:0]       spr_addr,
    output logic [FI_W-1:0]     first_idx,
    output logic                line_start,
    output logic                flag_clr,
    output logic                render_stb,
    output logic                spr_inval
);
    logic [HW-1:0] hcnt;
    fire_t         fire;
    logic          is_visible, is_vblank_start, is_first;
    logic          do_reload;

    phase_fsm #(
        .HW(HW), .POS_AFFINE(POS_AFFINE), .POS_DRAW(POS_DRAW), .POS_CFG(POS_CFG)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .line_len(line_len),
        .hcnt(hcnt), .fire(fire)
    );

    line_qual #(.VW(VW), .VIS_END(VIS_END), .VIS_END_OS(VIS_END_OS)) u_qual (
        .vpos(vpos), .overscan(overscan), .is_visible(is_visible),
        .is_vblank_start(is_vblank_start), .is_first(is_first)
    );

    affine_shadow #(.AW(AW), .N(N_AFF)) u_aff (
        .clk(clk), .rst_n(rst_n), .latch(fire.aff), .live(aff_live), .shadow(aff_shadow)
    );

    always_comb do_reload = fire.aff && is_vblank_start && !disp_off;

    spr_addr_reload #(.SB_W(SB_W), .FI_W(FI_W)) u_rel (
        .clk(clk), .rst_n(rst_n), .reload(do_reload), .prio_rot(prio_rot),
        .base(spr_base), .addr(spr_addr), .first_idx(first_idx)
    );

    spr_cfg_shadow #(.SZ_W(SZ_W), .NM_W(NM_W), .TD_W(TD_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .latch(fire.cfg),
        .size_live(spr_size), .name_live(spr_name), .tile_live(spr_tile),
        .size_sh(spr_size_sh), .name_sh(spr_name_sh), .tile_sh(spr_tile_sh),
        .inval(spr_inval)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_start <= 1'b0;
            flag_clr   <= 1'b0;
            render_stb <= 1'b0;
        end else begin
            line_start <= fire.ls;
            flag_clr   <= fire.ls && is_first;
            render_stb <= fire.draw && is_visible;
        end
    end

endmodule

// File: rtl/scan_seq_checker.sv
module scan_seq_checker #(
    parameter int HW         = 11,
    parameter int VW         = 9,
    parameter int VIS_END    = 225,
    parameter int VIS_END_OS = 240,
    parameter int AW_ALL     = 128,
    parameter int SA_W       = 10,
    parameter int FI_W       = 7,
    parameter int SZ_W       = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic [HW-1:0]     line_len,
    input logic [HW-1:0]     hcnt,
    input logic [VW-1:0]     vpos,
    input logic              overscan,
    input logic              disp_off,
    input logic              prio_rot,
    input logic              fire_aff,
    input logic [AW_ALL-1:0] aff_shadow,
    input logic [SA_W-1:0]   spr_addr,
    input logic [FI_W-1:0]   first_idx,
    input logic [SZ_W-1:0]   spr_size_sh,
    input logic              line_start,
    input logic              flag_clr,
    input logic              render_stb,
    input logic              spr_inval
);
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && (hcnt >= line_len - 1'b1)) |=> (hcnt == '0 && line_start));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(hcnt) && !line_start && !render_stb && !spr_inval));

    p_shadow_at_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (aff_shadow != $past(aff_shadow)) |-> $past(fire_aff));

    p_reload_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_addr != $past(spr_addr)) |-> ($past(fire_aff) && !$past(disp_off)));

    p_first_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((spr_addr != $past(spr_addr)) && !$past(prio_rot)) |-> (first_idx == '0));

    p_stb_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        render_stb |-> ($past(vpos) != '0 &&
                        $past(vpos) < ($past(overscan) ? VW'(VIS_END_OS) : VW'(VIS_END))));

    p_inval_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spr_inval |-> (spr_size_sh != $past(spr_size_sh)));

    p_clr_with_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |-> line_start);

endmodule

bind scanline_event_seq scan_seq_checker #(
    .HW(HW), .VW(VW), .VIS_END(VIS_END), .VIS_END_OS(VIS_END_OS),
    .AW_ALL(AW*N_AFF), .SA_W(SB_W+1), .FI_W(FI_W), .SZ_W(SZ_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .line_len(line_len), .hcnt(hcnt),
    .vpos(vpos), .overscan(overscan), .disp_off(disp_off), .prio_rot(prio_rot),
    .fire_aff(fire.aff), .aff_shadow(aff_shadow), .spr_addr(spr_addr),
    .first_idx(first_idx), .spr_size_sh(spr_size_sh), .line_start(line_start),
    .flag_clr(flag_clr), .render_stb(render_stb), .spr_inval(spr_inval)
);

// File: tb/sim_scanline_event_seq.sv
`timescale 1ns/1ps
module sim_scanline_event_seq;
    localparam int P_AFF = 3;
    localparam int P_DRW = 6;
    localparam int P_CFG = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic [10:0]  line_len = 11'd12;
    logic [8:0]   vpos = 9'd300;
    logic         overscan = 1'b0;
    logic         disp_off = 1'b1;
    logic         prio_rot = 1'b0;
    logic [8:0]   spr_base = '0;
    logic [127:0] aff_live = '0;
    logic [2:0]   spr_size = '0;
    logic [1:0]   spr_name = '0;
    logic [2:0]   spr_tile = '0;
    logic [127:0] aff_shadow;
    logic [2:0]   spr_size_sh;
    logic [1:0]   spr_name_sh;
    logic [2:0]   spr_tile_sh;
    logic [9:0]   spr_addr;
    logic [6:0]   first_idx;
    logic         line_start, flag_clr, render_stb, spr_inval;

    int checks = 0;
    int fails  = 0;
    bit cerand = 0;
    bit dforce = 0;

    logic [10:0]  hm = '0;
    logic [127:0] e_aff = '0;
    logic [9:0]   e_addr = '0;
    logic [6:0]   e_fi = '0;
    logic [2:0]   e_size = '0;
    logic [1:0]   e_name = '0;
    logic [2:0]   e_tile = '0;
    bit e_ls, e_clr, e_stb, e_inv;

    always #10 clk = ~clk;

    scanline_event_seq #(.POS_AFFINE(P_AFF), .POS_DRAW(P_DRW), .POS_CFG(P_CFG)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .line_len(line_len), .vpos(vpos),
        .overscan(overscan), .disp_off(disp_off), .prio_rot(prio_rot), .spr_base(spr_base),
        .aff_live(aff_live), .spr_size(spr_size), .spr_name(spr_name), .spr_tile(spr_tile),
        .aff_shadow(aff_shadow), .spr_size_sh(spr_size_sh), .spr_name_sh(spr_name_sh),
        .spr_tile_sh(spr_tile_sh), .spr_addr(spr_addr), .first_idx(first_idx),
        .line_start(line_start), .flag_clr(flag_clr), .render_stb(render_stb),
        .spr_inval(spr_inval)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (line %0d, h %0d)", tag, act, exp, vpos, hm);
        end
    endtask

    task automatic step();
        logic        ce;
        logic [10:0] hn;
        logic [8:0]  lim;
        bit          wr, aff, drw, cfg;
        ce = cerand ? ($urandom_range(0, 1) == 1) : 1'b1;
        tick_en  = ce;
        aff_live = {$urandom, $urandom, $urandom, $urandom};
        spr_base = 9'($urandom);
        prio_rot = 1'($urandom);
        disp_off = dforce ? 1'b1 : ($urandom_range(0, 3) == 0);
        spr_size = 3'($urandom_range(0, 1));
        spr_name = 2'($urandom);
        spr_tile = 3'($urandom);
        lim = overscan ? 9'd240 : 9'd225;
        wr  = ce && (hm >= line_len - 11'd1);
        hn  = hm;
        if (ce) hn = wr ? 11'd0 : hm + 11'd1;
        aff = ce && !wr && (hn == 11'(P_AFF));
        drw = ce && !wr && (hn == 11'(P_DRW));
        cfg = ce && !wr && (hn == 11'(P_CFG));
        e_ls  = wr;
        e_clr = wr && (vpos == 9'd0);
        e_stb = drw && (vpos >= 9'd1) && (vpos < lim);
        e_inv = cfg && (spr_size != e_size);
        if (aff) begin
            e_aff = aff_live;
            if (vpos == lim && !disp_off) begin
                e_addr = {spr_base, 1'b0};
                e_fi   = prio_rot ? e_addr[8:2] : 7'd0;
            end
        end
        if (cfg) begin
            e_size = spr_size;
            e_name = spr_name;
            e_tile = spr_tile;
        end
        hm = hn;
        @(posedge clk);
        @(negedge clk);
        chk(line_start == e_ls, "R1 line_start", 128'(line_start), 128'(e_ls));
        chk(aff_shadow == e_aff, "R2 aff_shadow", aff_shadow, e_aff);
        chk(spr_addr == e_addr, "R3 spr_addr", 128'(spr_addr), 128'(e_addr));
        chk(first_idx == e_fi, "R4 first_idx", 128'(first_idx), 128'(e_fi));
        chk(render_stb == e_stb, "R5 render_stb", 128'(render_stb), 128'(e_stb));
        chk(spr_inval == e_inv, "R6 spr_inval", 128'(spr_inval), 128'(e_inv));
        chk({spr_size_sh, spr_name_sh, spr_tile_sh} == {e_size, e_name, e_tile},
            "R6 cfg shadow", 128'({spr_size_sh, spr_name_sh, spr_tile_sh}),
            128'({e_size, e_name, e_tile}));
        chk(flag_clr == e_clr, "R7 flag_clr", 128'(flag_clr), 128'(e_clr));
        if (!ce)
            chk(!(line_start || render_stb || spr_inval || flag_clr), "R9 idle pulses",
                128'({line_start, render_stb, spr_inval, flag_clr}), 128'(0));
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({aff_shadow, spr_addr, first_idx, spr_size_sh, spr_name_sh, spr_tile_sh} == '0,
            "R8 reset shadows", 128'(aff_shadow), 128'(0));
        chk({line_start, flag_clr, render_stb, spr_inval} == 4'b0, "R8 reset pulses",
            128'({line_start, flag_clr, render_stb, spr_inval}), 128'(0));
        // warm-up line, then sweep every line number under several conditions
        do step(); while (hm != line_len - 11'd1);
        for (int p = 0; p < 6; p++) begin
            overscan = p[0];
            cerand   = (p == 2) || (p == 3);
            dforce   = (p >= 4);
            for (int l = 0; l < 246; l++) begin
                vpos = 9'(l);
                do step(); while (hm != 11'd0);
                line_len = 11'(10 + $urandom_range(0, 3));
                do step(); while (hm != line_len - 11'd1);
            end
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule